// File: doc/BRIEF.md
# Bus-Attached FIR Filter Engine

This block is a finite impulse response filter engine that sits on an APB slave port. A host drives everything through one 32-bit command word. The low three bits select an operation and bits [18:3] carry a 16-bit signed argument. With these commands the host sets the tap count, loads coefficients one at a time, fills the sample history with a constant, and pushes new input samples.

Each pushed sample is written at the head of a circular history. The engine then walks the taps one per clock and accumulates coefficient k times the sample k positions back. The sum is rounded from Q15 and clamped to 16 bits.

The host polls the ready flag in bit 31 of the read word and then takes the result from bits [15:0]. Coefficient and sample memories each hold `MAX_TAPS` entries, which defaults to 163.

Top module: `fir_apb_engine`

## Requirements
- R1: A command takes effect only on a clock edge where `psel`, `penable` and `pwrite` are all 1 and the engine is ready. A setup phase alone (`penable` = 0) changes nothing.
- R2: Opcode 4 sets the tap count to the payload, clamped to `MAX_TAPS`, and resets the coefficient write pointer to 0. It does not drop the ready flag.
- R3: Opcode 3 stores the payload as a coefficient at the write pointer and then advances the pointer, which wraps at `MAX_TAPS`. The first coefficient after opcode 4 is the one for the newest sample.
- R4: Opcode 1 writes the payload into every sample entry. Ready reads 0 for exactly `MAX_TAPS` cycles, and the previous result is kept.
- R5: Opcode 2 writes the payload at the history head and advances the head. Ready then reads 0 for exactly taps+1 cycles, after which the result equals the sum of coef[k]*x[n-k] for k from 0 to taps-1.
- R6: The output is formed by adding 2^14 to the sum and then shifting it arithmetically right by 15 (rounding half up).
- R7: A rounded value above 32767 reads as 32767, and one below -32768 reads as -32768.
- R8: Writes with opcode 0, 5, 6 or 7 are ignored. Ready stays 1 and no state changes.
- R9: Commands written while ready is 0 are dropped.
- R10: The read word is {ready, fifteen zeros, result}. After reset it reads 0x8000_0000.
- R11: With a tap count of 0, a push gives the result 0 after one busy cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB write strobe |
| pwdata | input | 32 | Command word: [2:0] opcode, [18:3] payload |
| prdata | output | 32 | Read word: [31] ready, [15:0] result |

## Verification
The assertions assume the host waits for ready before it issues a command. They also assume the history is filled before the first push, so that no unwritten memory word enters the sum. The tap counter is trusted never to pass the loaded count, and the write pointers are trusted to stay inside the memories.

The stimulus fills the history first and loads at least as many coefficients as the tap count before every push. It breaks the ready rule on purpose only once: a tap-count write lands while a convolution is running, to show that the write is dropped.

// File: rtl/fir_pkg.sv
package fir_pkg;
  localparam logic [2:0] OP_FILL = 3'd1;
  localparam logic [2:0] OP_PUSH = 3'd2;
  localparam logic [2:0] OP_COEF = 3'd3;
  localparam logic [2:0] OP_TAPS = 3'd4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_FILL = 2'd1,
    ST_MAC  = 2'd2
  } eng_state_t;
endpackage

// File: rtl/fir_ram.sv
module fir_ram #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 163,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [WIDTH-1:0]  wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [WIDTH-1:0]  rdata
);
  localparam logic [ADDR_W:0] DEPTH_L = DEPTH[ADDR_W:0];

  logic [WIDTH-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem_q[waddr] <= wdata;
  end

  always_comb begin
    if ({1'b0, raddr} < DEPTH_L) rdata = mem_q[raddr];
    else                         rdata = '0;
  end
endmodule

// File: rtl/fir_ctrl.sv
module fir_ctrl
  import fir_pkg::*;
#(
  parameter int MAX_TAPS = 163,
  parameter int DATA_W   = 16,
  localparam int ADDR_W  = $clog2(MAX_TAPS),
  localparam int CNT_W   = $clog2(MAX_TAPS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_acc,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] payload,
  output logic              ready,
  output logic              coef_we,
  output logic [ADDR_W-1:0] coef_waddr,
  output logic [ADDR_W-1:0] coef_raddr,
  output logic              smp_we,
  output logic [ADDR_W-1:0] smp_waddr,
  output logic [DATA_W-1:0] smp_wdata,
  output logic [ADDR_W-1:0] smp_raddr,
  output logic              mac_clear,
  output logic              mac_step,
  output logic              mac_done
);
  localparam logic [ADDR_W-1:0] LAST_IDX = ADDR_W'(MAX_TAPS - 1);
  localparam logic [CNT_W-1:0]  TAPS_MAX = CNT_W'(MAX_TAPS);
  localparam logic [DATA_W-1:0] TAPS_P   = DATA_W'(MAX_TAPS);
  localparam logic [CNT_W:0]    DEPTH_W  = (CNT_W+1)'(MAX_TAPS);

  eng_state_t        state_q, state_d;
  logic [CNT_W-1:0]  taps_q, taps_d;
  logic [CNT_W-1:0]  k_q, k_d;
  logic [ADDR_W-1:0] cptr_q, cptr_d;
  logic [ADDR_W-1:0] head_q, head_d;
  logic [ADDR_W-1:0] base_q, base_d;
  logic [ADDR_W-1:0] fptr_q, fptr_d;
  logic [DATA_W-1:0] fill_q, fill_d;
  logic              accept;
  logic [CNT_W:0]    base_w, k_w, idx_w;

  assign accept = wr_acc && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    taps_d  = taps_q;
    k_d     = k_q;
    cptr_d  = cptr_q;
    head_d  = head_q;
    base_d  = base_q;
    fptr_d  = fptr_q;
    fill_d  = fill_q;
    case (state_q)
      ST_IDLE: begin
        if (accept) begin
          case (opcode)
            OP_FILL: begin
              state_d = ST_FILL;
              fptr_d  = '0;
              fill_d  = payload;
            end
            OP_PUSH: begin
              state_d = ST_MAC;
              base_d  = head_q;
              head_d  = (head_q == LAST_IDX) ? '0 : head_q + 1'b1;
              k_d     = '0;
            end
            OP_COEF: cptr_d = (cptr_q == LAST_IDX) ? '0 : cptr_q + 1'b1;
            OP_TAPS: begin
              taps_d = (payload > TAPS_P) ? TAPS_MAX : payload[CNT_W-1:0];
              cptr_d = '0;
            end
            default: ;
          endcase
        end
      end
      ST_FILL: begin
        fptr_d = fptr_q + 1'b1;
        if (fptr_q == LAST_IDX) state_d = ST_IDLE;
      end
      ST_MAC: begin
        if (k_q == taps_q) state_d = ST_IDLE;
        else               k_d     = k_q + 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      taps_q  <= '0;
      k_q     <= '0;
      cptr_q  <= '0;
      head_q  <= '0;
      base_q  <= '0;
      fptr_q  <= '0;
      fill_q  <= '0;
    end else begin
      state_q <= state_d;
      taps_q  <= taps_d;
      k_q     <= k_d;
      cptr_q  <= cptr_d;
      head_q  <= head_d;
      base_q  <= base_d;
      fptr_q  <= fptr_d;
      fill_q  <= fill_d;
    end
  end

  // sample k positions behind the newest, modulo the history depth
  assign base_w = (CNT_W+1)'(base_q);
  assign k_w    = {1'b0, k_q};
  assign idx_w  = (base_w >= k_w) ? (base_w - k_w) : (base_w + DEPTH_W - k_w);

  assign ready      = (state_q == ST_IDLE);
  assign coef_we    = accept && (opcode == OP_COEF);
  assign coef_waddr = cptr_q;
  assign coef_raddr = ADDR_W'(k_q);
  assign smp_we     = (accept && (opcode == OP_PUSH)) || (state_q == ST_FILL);
  assign smp_waddr  = (state_q == ST_FILL) ? fptr_q : head_q;
  assign smp_wdata  = (state_q == ST_FILL) ? fill_q : payload;
  assign smp_raddr  = idx_w[ADDR_W-1:0];
  assign mac_clear  = accept && (opcode == OP_PUSH);
  assign mac_step   = (state_q == ST_MAC) && (k_q != taps_q);
  assign mac_done   = (state_q == ST_MAC) && (k_q == taps_q);

  assert_taps_clamped_R2: assert property (@(posedge clk) disable iff (!rst_n)
    taps_q <= TAPS_MAX);
  assert_fill_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_FILL) |-> (fptr_q <= LAST_IDX));
  assert_tap_walk_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MAC) |-> (k_q <= taps_q));
  assert_busy_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_acc && state_q != ST_IDLE) |=> ($stable(taps_q) && $stable(cptr_q)));
  assert_bad_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && (opcode == 3'd0 || opcode > 3'd4)) |=>
      (state_q == ST_IDLE && $stable(taps_q) && $stable(cptr_q) && $stable(head_q)));
endmodule

// File: rtl/fir_mac.sv
module fir_mac #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              step,
  input  logic              done,
  input  logic [DATA_W-1:0] coef,
  input  logic [DATA_W-1:0] smp,
  output logic [DATA_W-1:0] result
);
  localparam int FRAC = DATA_W - 1;
  localparam logic signed [ACC_W-1:0] RND  = ACC_W'(1) <<< (FRAC - 1);
  localparam logic signed [ACC_W-1:0] MAXV = {{(ACC_W-FRAC){1'b0}}, {FRAC{1'b1}}};
  localparam logic signed [ACC_W-1:0] MINV = {{(ACC_W-FRAC){1'b1}}, {FRAC{1'b0}}};

  logic signed [2*DATA_W-1:0] prod;
  logic signed [ACC_W-1:0]    acc_q, acc_d, rnd_sum, shifted;
  logic [DATA_W-1:0]          res_q, res_d;

  assign prod    = $signed(coef) * $signed(smp);
  assign rnd_sum = acc_q + RND;
  assign shifted = rnd_sum >>> FRAC;

  always_comb begin
    acc_d = acc_q;
    if (clear)     acc_d = '0;
    else if (step) acc_d = acc_q + ACC_W'(prod);
    res_d = res_q;
    if (done) begin
      if (shifted > MAXV)      res_d = MAXV[DATA_W-1:0];
      else if (shifted < MINV) res_d = MINV[DATA_W-1:0];
      else                     res_d = shifted[DATA_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      res_q <= '0;
    end else begin
      acc_q <= acc_d;
      res_q <= res_d;
    end
  end

  assign result = res_q;

  assert_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (acc_q == '0));
  assert_result_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q));
endmodule

// File: rtl/fir_apb_engine.sv
module fir_apb_engine #(
  parameter int MAX_TAPS = 163,
  parameter int ACC_W    = 40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        psel,
  input  logic        penable,
  input  logic        pwrite,
  input  logic [31:0] pwdata,
  output logic [31:0] prdata
);
  localparam int DATA_W = 16;
  localparam int ADDR_W = $clog2(MAX_TAPS);

  logic              wr_acc, ready;
  logic              coef_we, smp_we, mac_clear, mac_step, mac_done;
  logic [ADDR_W-1:0] coef_waddr, coef_raddr, smp_waddr, smp_raddr;
  logic [DATA_W-1:0] smp_wdata, coef_rdata, smp_rdata, result, payload;

  assign wr_acc  = psel && penable && pwrite;
  assign payload = pwdata[18:3];

  fir_ctrl #(.MAX_TAPS(MAX_TAPS), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_acc(wr_acc), .opcode(pwdata[2:0]),
    .payload(payload), .ready(ready), .coef_we(coef_we),
    .coef_waddr(coef_waddr), .coef_raddr(coef_raddr), .smp_we(smp_we),
    .smp_waddr(smp_waddr), .smp_wdata(smp_wdata), .smp_raddr(smp_raddr),
    .mac_clear(mac_clear), .mac_step(mac_step), .mac_done(mac_done)
  );

  fir_ram #(.WIDTH(DATA_W), .DEPTH(MAX_TAPS)) u_coef_ram (
    .clk(clk), .we(coef_we), .waddr(coef_waddr), .wdata(payload),
    .raddr(coef_raddr), .rdata(coef_rdata)
  );

  fir_ram #(.WIDTH(DATA_W), .DEPTH(MAX_TAPS)) u_smp_ram (
    .clk(clk), .we(smp_we), .waddr(smp_waddr), .wdata(smp_wdata),
    .raddr(smp_raddr), .rdata(smp_rdata)
  );

  fir_mac #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_mac (
    .clk(clk), .rst_n(rst_n), .clear(mac_clear), .step(mac_step),
    .done(mac_done), .coef(coef_rdata), .smp(smp_rdata), .result(result)
  );

  assign prdata = {ready, {(31-DATA_W){1'b0}}, result};

  assert_setup_inert_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && !(psel && penable && pwrite)) |=> ready);
endmodule

// File: tb/fir_apb_engine_test.sv
module fir_apb_engine_test;
  localparam int DEPTH = 163;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;

  always #10 clk = ~clk;

  fir_apb_engine uut (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable),
    .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata)
  );

  typedef struct {
    int    res;
    int    busy;
    string tag;
  } item_t;

  item_t sbq[$];
  int n_cmp = 0;
  int n_bad = 0;
  int busy_cnt = 0;

  int coef_m [DEPTH];
  int smp_m  [DEPTH];
  int head_m = 0, taps_m = 0, cptr_m = 0, last_m = 0;

  task automatic check(input string tag, input longint act, input longint exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: count busy cycles, compare when ready returns
  always @(negedge clk) begin
    if (rst_n) begin
      if (!prdata[31]) busy_cnt++;
      else if (busy_cnt > 0) begin
        if (sbq.size() == 0) check("unexpected busy", busy_cnt, 0);
        else begin
          item_t it;
          it = sbq.pop_front();
          check({it.tag, " result"}, longint'($signed(prdata[15:0])), it.res);
          check({it.tag, " busy cycles"}, busy_cnt, it.busy);
        end
        busy_cnt = 0;
      end
    end
  end

  task automatic apb_write(input logic [2:0] op, input int val);
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0;
    pwdata = {13'd0, val[15:0], op};
    @(negedge clk);
    penable = 1'b1;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
  endtask

  task automatic wait_ready();
    while (!prdata[31]) @(negedge clk);
    @(negedge clk);
  endtask

  function automatic int sat_round(input longint acc);
    longint r;
    r = (acc + 16384) >>> 15;
    if (r > 32767)  r = 32767;
    if (r < -32768) r = -32768;
    return int'(r);
  endfunction

  task automatic do_taps(input int n);
    apb_write(3'd4, n);
    taps_m = (n > DEPTH) ? DEPTH : n;
    cptr_m = 0;
  endtask

  task automatic do_coef(input int v);
    apb_write(3'd3, v);
    coef_m[cptr_m] = v;
    cptr_m = (cptr_m + 1) % DEPTH;
  endtask

  task automatic do_fill(input int v);
    apb_write(3'd1, v);
    for (int i = 0; i < DEPTH; i++) smp_m[i] = v;
    sbq.push_back('{last_m, DEPTH, "R4 fill"});
    wait_ready();
  endtask

  task automatic model_push(input int v, input string tag);
    longint acc = 0;
    smp_m[head_m] = v;
    for (int k = 0; k < taps_m; k++)
      acc += longint'(coef_m[k]) * longint'(smp_m[(head_m - k + DEPTH) % DEPTH]);
    head_m = (head_m + 1) % DEPTH;
    last_m = sat_round(acc);
    sbq.push_back('{last_m, taps_m + 1, tag});
  endtask

  task automatic do_push(input int v, input string tag);
    apb_write(3'd2, v);
    model_push(v, tag);
    wait_ready();
  endtask

  bit finished = 1'b0;

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset word", prdata, 32'h8000_0000);
    rst_n = 1'b1;
    @(negedge clk);

    do_fill(0);

    // R3 R5: four taps, mixed signs
    do_taps(4);
    do_coef(16384); do_coef(8192); do_coef(-4096); do_coef(100);
    do_push(1000,   "R5 push a");
    do_push(-2000,  "R5 push b");
    do_push(32767,  "R5 push c");
    do_push(-32768, "R5 push d");
    do_push(5,      "R5 push e");

    // R1: setup phase only, never enabled
    @(negedge clk);
    psel = 1'b1; pwrite = 1'b1; penable = 1'b0; pwdata = {13'd0, 16'd77, 3'd2};
    repeat (3) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    @(negedge clk);
    check("R1 ready after setup-only", prdata[31], 1);
    check("R1 result kept", longint'($signed(prdata[15:0])), last_m);

    // R8: reserved opcodes
    apb_write(3'd0, 9); apb_write(3'd5, 0); apb_write(3'd6, 3); apb_write(3'd7, 1);
    check("R8 ready after bad ops", prdata[31], 1);
    @(negedge clk);
    check("R8 result kept", longint'($signed(prdata[15:0])), last_m);
    do_push(300, "R8 taps intact");

    // R9: tap write during convolution is dropped
    apb_write(3'd2, 1234);
    model_push(1234, "R9 busy push");
    apb_write(3'd4, 1);
    wait_ready();
    do_push(-77, "R9 taps still 4");

    // R6: rounding half up
    do_taps(1); do_coef(1);
    do_push(16384, "R6 half rounds up");
    do_push(16383, "R6 below half");
    do_taps(1); do_coef(-1);
    do_push(16384, "R6 neg half");
    do_push(16385, "R6 neg past half");

    // R11: zero taps
    do_taps(0);
    do_push(7, "R11 zero taps");

    // R2 R7: clamped tap count, saturation both ways
    do_taps(500);
    for (int i = 0; i < DEPTH; i++) do_coef(32767);
    do_fill(32767);
    do_push(32767, "R7 R2 positive clamp");
    do_fill(-32768);
    do_push(-32768, "R7 negative clamp");
    check("R10 pad bits zero", prdata[30:16], 0);
    check("R10 ready bit", prdata[31], 1);

    repeat (4) @(negedge clk);
    check("scoreboard drained", sbq.size(), 0);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule